// File: doc/BRIEF.md
# Tiered Tamper Response Controller

This block sits inside a secure microcontroller and turns tamper indications into protective actions. It watches three kinds of source: flags from sensors on the die, external self-destruct pins, and a mismatch flag from the program-memory block checksum check. Each source is synchronised and must hold for a programmable number of cycles before it counts as an event.

Each qualified event requests a response level. A die sensor asks for key erasure only. A self-destruct pin asks for the full response: key erasure, a zero-writing sweep of internal RAM, and removal of power from the external battery-backed SRAM. A checksum mismatch asks for whatever level software has configured. The level is held until power-on reset and can only go up. The block also drives a sticky interrupt and records which sources caused the first event.

While keys or RAM are being destroyed, the block forces the key-store and RAM read data it passes on to zero.

Top module: `tamper_resp_ctrl`

## Requirements
- R1: A tamper input passes through two synchronising flops and counts as an event only after its synchronised copy has been high for Q consecutive clocks, where Q is `qual_thr_i` (a value of 0 acts as 1). A shorter pulse has no effect. `key_zero_o` first rises after the rising edge numbered Q+2, counting the edge that first samples the input high.
- R2: A die-sensor event sets `level_o` to 1 (keys). It starts no RAM sweep and does not change the external power enables.
- R3: A self-destruct pin event sets `level_o` to 2 (full). On the clock after the level reaches 2, a sweep starts that asserts `ram_we_o` with `ram_wdata_o` at zero. It visits addresses 0 to CLR_DEPTH-1 in order, one per clock.
- R4: Below level 2, exactly one external supply enable is high: `pwr_vcc_en_o` when `supply_sel_i` is 0, and `pwr_bat_en_o` when it is 1. At level 2 both are low.
- R5: A checksum-mismatch event requests the configured level: 0 means no erasure, 1 means keys, 2 means full, and 3 is treated as 2.
- R6: `level_o` never decreases before reset, and a later event only raises it. `irq_o` goes high with the first event of any source, including a checksum event configured to level 0, and stays high.
- R7: `cause_o` captures the sources of the first event: bit 0 for die sensor, bit 1 for pin, bit 2 for checksum. Several bits are set when sources qualify in the same clock. It then never changes.
- R8: A configuration write (`cfg_we_i`) updates `cfg_level_o` only when no event has been latched and no event qualifies in that same clock. Otherwise the write is dropped. The reset value is 1.
- R9: At any nonzero level, `key_rdata_o` reads zero. At level 2, `ram_rdata_o` reads zero until the sweep completes. Otherwise both pass the raw data through.
- R10: `key_zero_o` pulses for exactly one clock, when the level first leaves 0. When the first event is a pin, this pulse comes one clock before the first RAM write. A later upgrade from 1 to 2 does not repeat it.
- R11: After the write to the last address, `ram_done_o` goes high on the next clock and stays high. `ram_we_o` stays low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| die_sens_i | input | NS | Die tamper sensor flags |
| sd_pin_i | input | NP | External self-destruct pins |
| csum_bad_i | input | 1 | Program-memory checksum mismatch flag |
| qual_thr_i | input | QW | Qualification length in cycles |
| cfg_we_i | input | 1 | Write strobe for the checksum response level |
| cfg_wlvl_i | input | 2 | Level to write |
| cfg_level_o | output | 2 | Current checksum response level |
| supply_sel_i | input | 1 | Normal supply choice: 0 for VCC, 1 for battery |
| key_raw_i | input | KW | Raw key-store read data |
| key_rdata_o | output | KW | Gated key-store read data |
| ram_raw_i | input | DW | Raw internal RAM read data |
| ram_rdata_o | output | DW | Gated internal RAM read data |
| key_zero_o | output | 1 | Key-store zeroize strobe |
| ram_we_o | output | 1 | Sweep write enable |
| ram_addr_o | output | AW | Sweep address |
| ram_wdata_o | output | DW | Sweep write data, always zero |
| ram_done_o | output | 1 | Sweep finished |
| pwr_vcc_en_o | output | 1 | External SRAM supply from VCC |
| pwr_bat_en_o | output | 1 | External SRAM supply from battery |
| irq_o | output | 1 | Sticky tamper interrupt |
| cause_o | output | 3 | Sources of the first event |
| level_o | output | 2 | Latched response level |

## Verification
Two pairs of actions can land in the same clock.

The first pair is a configuration write and the first checksum event. The bench holds the mismatch flag, counts the synchroniser and qualification cycles, and pulses `cfg_we_i` in exactly the clock where the event qualifies. It then expects the old level to govern the response and the write to be dropped.

The second pair is a die sensor and a pin qualifying together. The expected result is a `cause_o` with both bits set, a single zeroize pulse, and the full response. A behavioural model compares every output on every clock, so a one-cycle slip in the strobe or the sweep is also caught.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_KEYS = 2'd1;
  localparam logic [1:0] LVL_FULL = 2'd2;

  // larger of two response levels
  function automatic logic [1:0] lvl_max(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  // configured checksum level to requested level (3 behaves as full)
  function automatic logic [1:0] csum_map(input logic [1:0] cfg);
    return (cfg == 2'd3) ? LVL_FULL : cfg;
  endfunction
endpackage

// File: rtl/tamper_qual.sv
module tamper_qual #(
  parameter int W  = 4,
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  raw_i,
  input  logic [QW-1:0] thr_i,
  output logic [W-1:0]  hit_o
);
  localparam logic [QW-1:0] CNT_MAX = '1;

  logic [QW-1:0] thr_m1;
  assign thr_m1 = (thr_i == '0) ? '0 : thr_i - 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_ch
    logic s1, s2;
    logic [QW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b0;
        s2  <= 1'b0;
        cnt <= '0;
      end else begin
        s1 <= raw_i[i];
        s2 <= s1;
        if (!s2)                cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
    assign hit_o[i] = s2 && (cnt >= thr_m1);
  end
endmodule

// File: rtl/tamper_clear_seq.sv
module tamper_clear_seq #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DONE} sq_e;
  sq_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      addr_o <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (go_i) begin
          st     <= SQ_RUN;
          addr_o <= '0;
        end
        SQ_RUN: begin
          if (addr_o == LAST) st <= SQ_DONE;
          else                addr_o <= addr_o + 1'b1;
        end
        default: st <= SQ_DONE;
      endcase
    end
  end

  assign we_o   = (st == SQ_RUN);
  assign done_o = (st == SQ_DONE);
endmodule

// File: rtl/tamper_resp_ctrl.sv
module tamper_resp_ctrl
  import tamper_pkg::*;
#(
  parameter int NS        = 4,
  parameter int NP        = 2,
  parameter int QW        = 4,
  parameter int CLR_DEPTH = 16,
  parameter int KW        = 64,
  parameter int DW        = 32,
  parameter int AW        = $clog2(CLR_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] die_sens_i,
  input  logic [NP-1:0] sd_pin_i,
  input  logic          csum_bad_i,
  input  logic [QW-1:0] qual_thr_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_wlvl_i,
  output logic [1:0]    cfg_level_o,
  input  logic          supply_sel_i,
  input  logic [KW-1:0] key_raw_i,
  output logic [KW-1:0] key_rdata_o,
  input  logic [DW-1:0] ram_raw_i,
  output logic [DW-1:0] ram_rdata_o,
  output logic          key_zero_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          ram_done_o,
  output logic          pwr_vcc_en_o,
  output logic          pwr_bat_en_o,
  output logic          irq_o,
  output logic [2:0]    cause_o,
  output logic [1:0]    level_o
);
  localparam int NT = NS + NP + 1;

  // qualified source flags, one per input line
  logic [NT-1:0] hit;
  tamper_qual #(.W(NT), .QW(QW)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i ({csum_bad_i, sd_pin_i, die_sens_i}),
    .thr_i (qual_thr_i),
    .hit_o (hit)
  );

  // named internal events
  logic       sens_hit, pin_hit, csum_hit, evt_now;
  logic [1:0] req_lvl, lvl_q, cfg_q;
  logic       seen_q, zero_q, clr_go, sweep_done;

  assign sens_hit = |hit[NS-1:0];
  assign pin_hit  = |hit[NS+NP-1:NS];
  assign csum_hit = hit[NT-1];
  assign evt_now  = sens_hit | pin_hit | csum_hit;

  always_comb begin
    req_lvl = LVL_NONE;
    if (sens_hit) req_lvl = lvl_max(req_lvl, LVL_KEYS);
    if (csum_hit) req_lvl = lvl_max(req_lvl, csum_map(cfg_q));
    if (pin_hit)  req_lvl = lvl_max(req_lvl, LVL_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LVL_NONE;
      zero_q  <= 1'b0;
      seen_q  <= 1'b0;
      cause_o <= 3'b000;
      cfg_q   <= LVL_KEYS;
    end else begin
      zero_q <= (lvl_q == LVL_NONE) && (req_lvl != LVL_NONE);
      lvl_q  <= lvl_max(lvl_q, req_lvl);
      if (evt_now && !seen_q) begin
        seen_q  <= 1'b1;
        cause_o <= {csum_hit, pin_hit, sens_hit};
      end
      if (cfg_we_i && !seen_q && !evt_now) cfg_q <= cfg_wlvl_i;
    end
  end

  assign clr_go = (lvl_q == LVL_FULL);

  tamper_clear_seq #(.DEPTH(CLR_DEPTH), .AW(AW)) u_clr (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (clr_go),
    .we_o   (ram_we_o),
    .addr_o (ram_addr_o),
    .done_o (sweep_done)
  );

  assign ram_wdata_o  = '0;
  assign ram_done_o   = sweep_done;
  assign key_zero_o   = zero_q;
  assign level_o      = lvl_q;
  assign irq_o        = seen_q;
  assign cfg_level_o  = cfg_q;
  assign pwr_vcc_en_o = !clr_go && !supply_sel_i;
  assign pwr_bat_en_o = !clr_go && supply_sel_i;
  assign key_rdata_o  = (lvl_q != LVL_NONE) ? '0 : key_raw_i;
  assign ram_rdata_o  = (clr_go && !sweep_done) ? '0 : ram_raw_i;
endmodule

// File: rtl/tamper_resp_ctrl_chk.sv
module tamper_resp_ctrl_chk #(
  parameter int AW = 4,
  parameter int KW = 64,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    level_o,
  input logic          key_zero_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o,
  input logic          ram_done_o,
  input logic          pwr_vcc_en_o,
  input logic          pwr_bat_en_o,
  input logic          irq_o,
  input logic [2:0]    cause_o,
  input logic [KW-1:0] key_rdata_o,
  input logic [DW-1:0] ram_rdata_o,
  input logic          evt_now
);
  assert_zero_on_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_zero_o |-> (level_o != 2'd0 && $past(level_o) == 2'd0));
  assert_level_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level_o >= $past(level_o));
  assert_clear_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (level_o == 2'd2 && !pwr_vcc_en_o && !pwr_bat_en_o));
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && $past(ram_we_o)) |-> ram_addr_o == $past(ram_addr_o) + 1'b1);
  assert_sweep_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_o) |-> ram_addr_o == '0);
  assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_o) |-> $stable(cause_o));
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_o) |-> irq_o);
  assert_event_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_now |=> irq_o);
  assert_ram_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> ram_rdata_o == '0);
  assert_key_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != 2'd0) |-> key_rdata_o == '0);
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_done_o |-> (!ram_we_o && level_o == 2'd2));
  assert_supply_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_vcc_en_o && pwr_bat_en_o));
endmodule

bind tamper_resp_ctrl tamper_resp_ctrl_chk #(.AW(AW), .KW(KW), .DW(DW)) u_chk (.*);

// File: tb/tamper_resp_ctrl_bench.sv
module tamper_resp_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, NP = 2, QW = 4, DEPTH = 16, KW = 64, DW = 32;
  localparam int AW = $clog2(DEPTH);
  localparam int NT = NS + NP + 1;
  localparam logic [KW-1:0] KEYPAT = 64'hA5A5_0123_4567_89AB;
  localparam logic [DW-1:0] RAMPAT = 32'hDEAD_BEEF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] die_sens = '0;
  logic [NP-1:0] sd_pin = '0;
  logic csum_bad = 1'b0, cfg_we = 1'b0, supply_sel = 1'b0;
  logic [QW-1:0] qual_thr = '0;
  logic [1:0] cfg_wlvl = '0;
  logic [1:0] cfg_level, level;
  logic [KW-1:0] key_rdata;
  logic [DW-1:0] ram_rdata, ram_wdata;
  logic key_zero, ram_we, ram_done, pwr_vcc, pwr_bat, irq;
  logic [AW-1:0] ram_addr;
  logic [2:0] cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_resp_ctrl u_tamper_resp_ctrl (
    .clk(clk), .rst_n(rst_n), .die_sens_i(die_sens), .sd_pin_i(sd_pin),
    .csum_bad_i(csum_bad), .qual_thr_i(qual_thr), .cfg_we_i(cfg_we),
    .cfg_wlvl_i(cfg_wlvl), .cfg_level_o(cfg_level), .supply_sel_i(supply_sel),
    .key_raw_i(KEYPAT), .key_rdata_o(key_rdata), .ram_raw_i(RAMPAT),
    .ram_rdata_o(ram_rdata), .key_zero_o(key_zero), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_done_o(ram_done),
    .pwr_vcc_en_o(pwr_vcc), .pwr_bat_en_o(pwr_bat), .irq_o(irq),
    .cause_o(cause), .level_o(level)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_s1[NT], m_s2[NT], m_cnt[NT];
  int m_lvl, m_cfg, m_cause, m_state, m_addr;
  bit m_seen, m_zero;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_s1[i]) begin m_s1[i] = 0; m_s2[i] = 0; m_cnt[i] = 0; end
      m_lvl = 0; m_cfg = 1; m_cause = 0; m_state = 0; m_addr = 0;
      m_seen = 0; m_zero = 0;
    end else begin
      int thr, req;
      bit sq, pq, cq, ev;
      bit [NT-1:0] raw;
      raw = {csum_bad, sd_pin, die_sens};
      thr = (qual_thr == 0) ? 1 : int'(qual_thr);
      sq = 0; pq = 0; cq = 0;
      for (int i = 0; i < NT; i++) begin
        if (m_s2[i] == 1 && m_cnt[i] >= thr - 1) begin
          if (i < NS) sq = 1;
          else if (i < NS + NP) pq = 1;
          else cq = 1;
        end
      end
      req = 0;
      if (sq) req = 1;
      if (cq) req = (req > ((m_cfg == 3) ? 2 : m_cfg)) ? req : ((m_cfg == 3) ? 2 : m_cfg);
      if (pq) req = 2;
      ev = sq | pq | cq;
      m_zero = (m_lvl == 0) && (req > 0);
      if (m_state == 0 && m_lvl == 2) begin m_state = 1; m_addr = 0; end
      else if (m_state == 1) begin
        if (m_addr == DEPTH - 1) m_state = 2; else m_addr++;
      end
      if (cfg_we && !m_seen && !ev) m_cfg = int'(cfg_wlvl);
      if (ev && !m_seen) begin m_seen = 1; m_cause = cq * 4 + pq * 2 + sq; end
      if (req > m_lvl) m_lvl = req;
      for (int i = 0; i < NT; i++) begin
        if (m_s2[i] == 0) m_cnt[i] = 0;
        else if (m_cnt[i] < (1 << QW) - 1) m_cnt[i]++;
        m_s2[i] = m_s1[i];
        m_s1[i] = int'(raw[i]);
      end
    end
  end

  // compare every output on every clock, away from the active edge
  always @(negedge clk) begin
    chk("R10 key_zero", 64'(key_zero), 64'(m_zero));
    chk("R6 level", 64'(level), 64'(m_lvl));
    chk("R3 ram_we", 64'(ram_we), 64'(m_state == 1));
    if (m_state == 1) chk("R3 ram_addr", 64'(ram_addr), 64'(m_addr));
    chk("R3 ram_wdata", 64'(ram_wdata), 64'd0);
    chk("R11 ram_done", 64'(ram_done), 64'(m_state == 2));
    chk("R4 pwr_vcc", 64'(pwr_vcc), 64'(m_lvl != 2 && !supply_sel));
    chk("R4 pwr_bat", 64'(pwr_bat), 64'(m_lvl != 2 && supply_sel));
    chk("R6 irq", 64'(irq), 64'(m_seen));
    chk("R7 cause", 64'(cause), 64'(m_cause));
    chk("R8 cfg_level", 64'(cfg_level), 64'(m_cfg));
    chk("R9 key_rdata", key_rdata, (m_lvl != 0) ? 64'd0 : KEYPAT);
    chk("R9 ram_rdata", 64'(ram_rdata), (m_lvl == 2 && m_state != 2) ? 64'd0 : 64'(RAMPAT));
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; die_sens = '0; sd_pin = '0; csum_bad = 1'b0;
    cfg_we = 1'b0; supply_sel = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic [1:0] v);
    cfg_we = 1'b1; cfg_wlvl = v;
    tick(1);
    cfg_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    tick(1);
    do_reset();
    tick(1);
    // reset state
    chk("R6 reset level", 64'(level), 64'd0);
    chk("R8 reset cfg", 64'(cfg_level), 64'd1);
    chk("R4 reset vcc", 64'(pwr_vcc), 64'd1);
    supply_sel = 1'b1; tick(1);
    chk("R4 battery chosen", 64'(pwr_bat && !pwr_vcc), 64'd1);

    // R1: too-short pulse ignored, then a long enough one
    qual_thr = 4'd3;
    die_sens[1] = 1'b1; tick(2); die_sens[1] = 1'b0;
    tick(8);
    chk("R1 short pulse level", 64'(level), 64'd0);
    chk("R1 short pulse irq", 64'(irq), 64'd0);
    die_sens[1] = 1'b1; tick(3); die_sens[1] = 1'b0;
    tick(8);
    chk("R1 qualified level", 64'(level), 64'd1);
    chk("R2 sensor keys only", 64'(level), 64'd1);
    chk("R2 no sweep", 64'(ram_we | ram_done), 64'd0);
    chk("R2 power kept", 64'(pwr_bat), 64'd1);
    chk("R7 sensor cause", 64'(cause), 64'd1);

    // R3: pin upgrades to full
    sd_pin[0] = 1'b1; tick(4); sd_pin[0] = 1'b0;
    tick(DEPTH + 10);
    chk("R3 full level", 64'(level), 64'd2);
    chk("R11 done", 64'(ram_done), 64'd1);
    chk("R4 power cut", 64'(pwr_vcc | pwr_bat), 64'd0);
    chk("R7 cause kept", 64'(cause), 64'd1);

    // R10: strobe precedes first write by one clock
    do_reset();
    qual_thr = 4'd0;
    sd_pin[1] = 1'b1; tick(1); sd_pin[1] = 1'b0;
    for (int i = 0; i < 10 && !key_zero; i++) @(negedge clk);
    chk("R10 strobe seen", 64'(key_zero), 64'd1);
    @(negedge clk);
    chk("R10 strobe one cycle", 64'(key_zero), 64'd0);
    chk("R10 first write follows", 64'(ram_we && ram_addr == 0), 64'd1);
    tick(DEPTH + 4);
    chk("R11 done after pin", 64'(ram_done), 64'd1);

    // R5/R8: checksum at level 0 then locked config
    do_reset();
    qual_thr = 4'd1;
    cfg_write(2'd0);
    chk("R8 write accepted", 64'(cfg_level), 64'd0);
    csum_bad = 1'b1; tick(2); csum_bad = 1'b0;
    tick(6);
    chk("R5 level zero response", 64'(level), 64'd0);
    chk("R6 irq from checksum", 64'(irq), 64'd1);
    chk("R7 checksum cause", 64'(cause), 64'd4);
    cfg_write(2'd2);
    chk("R8 write ignored", 64'(cfg_level), 64'd0);
    die_sens[3] = 1'b1; tick(2); die_sens[3] = 1'b0;
    tick(6);
    chk("R6 raised by sensor", 64'(level), 64'd1);
    chk("R7 cause unchanged", 64'(cause), 64'd4);

    // R8/R5: write in the very clock the checksum event qualifies
    do_reset();
    qual_thr = 4'd2;
    cfg_write(2'd3);
    csum_bad = 1'b1;
    tick(3);
    cfg_we = 1'b1; cfg_wlvl = 2'd1;
    tick(1);
    cfg_we = 1'b0; csum_bad = 1'b0;
    tick(4);
    chk("R8 same-cycle write dropped", 64'(cfg_level), 64'd3);
    chk("R5 code 3 is full", 64'(level), 64'd2);
    tick(DEPTH + 4);

    // R7: two sources together
    do_reset();
    qual_thr = 4'd1;
    die_sens[0] = 1'b1; sd_pin[1] = 1'b1; tick(1);
    die_sens[0] = 1'b0; sd_pin[1] = 1'b0;
    tick(6);
    chk("R7 joint cause", 64'(cause), 64'd3);
    chk("R3 joint full", 64'(level), 64'd2);
    tick(DEPTH + 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule